// File: doc/BRIEF.md
# Wakeup and Kickstart Power Controller

This block raises a power-up request for a system whose clock keeps running from a backup battery while main power is off. Two independent sources can wake the system. The first is a time-of-day alarm: the current day/date, hours, minutes and seconds are compared with four alarm bytes. The second is a kickstart input, such as a key closure or a ring-detect line, which must stay low for a minimum number of timebase ticks. Each source has its own sticky status flag, so software can tell afterwards which one woke the system.

When either source fires, the block drives an active-low power-enable output. It then waits a bounded number of ticks for the main supply to report good. If the supply comes up in time, the output stays driven and the system runs. If it does not, the output goes back to high impedance and the block waits for the next event. The state machine has three states:

- `PS_IDLE`: output released.
- `PS_DRIVE`: output driven, power-on timer running.
- `PS_HOLD`: output driven, supply confirmed good.

The transitions are:

- `accept` (IDLE to DRIVE): a wake or kickstart event arrives while the battery is present.
- `supply_up` (DRIVE to HOLD): main supply good.
- `timeout` (DRIVE to IDLE): the timer expires without the supply coming up.
- `supply_down` (HOLD to IDLE): main supply lost.
- `battery_lost` (DRIVE or HOLD to IDLE): the auxiliary battery goes away.

Top module: `wk_power_ctl`

## Requirements
- R1: After reset, `pwr_oe` is 0, `pwr_n` is 1, and both `tdf` and `ksf` are 0.
- R2: An alarm wake is armed when all of these hold: `wake_en`=1, `xfer_en`=1, `vbaux_ok`=1, `osc_run`=1 and `vcc_good`=0. If all four time fields then become equal to their alarm bytes, the clock edge that sees the match sets `pwr_oe`=1, `pwr_n`=0 and `tdf`=1.
- R3: Any one of the following prevents a wake: a mismatch in any single field (day, hour, minute or second), or any one arming condition of R2 not being met.
- R4: Kickstart needs `ks_n` to be sampled high and then to stay sampled low for `KS_MIN_TICKS` consecutive tick cycles. It drives the output two clocks after the last qualifying sample and sets `ksf`. A low pulse that is one tick shorter is ignored.
- R5: Kickstart works only while `vbaux_ok`=1, `osc_run`=1 and `vcc_good`=0. Holding `ks_n` low produces only one event; the input must return high before it can re-trigger.
- R6: Without `vcc_good`, the output stays driven for exactly `PWR_TIMEOUT_TICKS` tick cycles and is then released (`pwr_oe`=0, `pwr_n`=1). Cycles with `tick`=0 do not advance the timer.
- R7: If `vcc_good` is 1 while the output is driven, the output stays driven past the timeout. It is released one clock after `vcc_good` falls.
- R8: `tdf` and `ksf` stay set until a cycle with `flag_rd`=1, which clears both at the next edge. A flag being set in the same cycle takes priority over the clear.
- R9: Wake and kickstart events that arrive while the output is driven are not accepted and set no flag.
- R10: When `vbaux_ok` falls, a driven output is released at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe, one cycle per tick |
| cur_day | input | 8 | Current day/date |
| cur_hour | input | 8 | Current hours |
| cur_min | input | 8 | Current minutes |
| cur_sec | input | 8 | Current seconds |
| alm_day | input | 8 | Day/date alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_sec | input | 8 | Seconds alarm byte |
| wake_en | input | 1 | Alarm wake enable |
| xfer_en | input | 1 | Time transfer enable, also required for an alarm wake |
| vcc_good | input | 1 | Main supply above its switch threshold |
| vbaux_ok | input | 1 | Auxiliary battery present |
| osc_run | input | 1 | Oscillator running |
| ks_n | input | 1 | Kickstart input, active low |
| flag_rd | input | 1 | Flag register read strobe, clears both flags |
| pwr_n | output | 1 | Power-enable level, active low |
| pwr_oe | output | 1 | Output enable for the power-enable pin; 0 means high impedance |
| tdf | output | 1 | Alarm wake flag |
| ksf | output | 1 | Kickstart flag |

## Verification
The alarm comparator is driven with a full match and then with each of the four fields wrong by one, which shows that every field takes part in the compare. Each of the five arming conditions is also withheld in turn, which shows that every condition gates the wake. Kickstart is driven with three patterns: a pulse exactly at the minimum width, a pulse one tick short, and a level held low. Together these separate correct qualification from an off-by-one count and from retriggering on a level. The power-on timer is checked three ways: with no supply, with the supply arriving early, and with ticks stopped. Comparing them shows that release depends only on the tick count and the supply state.

// File: rtl/wk_power_pkg.sv
package wk_power_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_DRIVE = 2'd1,
        PS_HOLD  = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } tod_t;

endpackage

// File: rtl/wk_alarm_cmp.sv
module wk_alarm_cmp
    import wk_power_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  tod_t cur,
    input  tod_t alm,
    output logic hit
);
    logic match;
    logic match_q;

    // A full four-field match counts only while the wake path is armed.
    assign match = arm && (cur == alm);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= match;
        end
    end

    // One event per match episode.
    assign hit = match && !match_q;
endmodule

// File: rtl/wk_ks_qual.sv
module wk_ks_qual #(
    parameter int MIN_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic ks_n,
    output logic fire
);
    localparam int CW = $clog2(MIN_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_TICKS - 1);

    logic          s1, s2;
    logic          armed;
    logic [CW-1:0] cnt;

    // Two-stage synchroniser for the asynchronous pin.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= ks_n;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (!active) begin
            armed <= s2;
            cnt   <= '0;
        end else if (s2) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (tick && armed) begin
            if (cnt == LAST) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign fire = active && !s2 && tick && armed && (cnt == LAST);
endmodule

// File: rtl/wk_pwr_fsm.sv
module wk_pwr_fsm
    import wk_power_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic vbaux_ok,
    input  logic vcc_good,
    input  logic wake_hit,
    input  logic ks_hit,
    input  logic flag_rd,
    output logic pwr_n,
    output logic pwr_oe,
    output logic tdf,
    output logic ksf
);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_TICKS - 1);

    pwr_state_e    state, state_nx;
    logic [TW-1:0] tmr;
    logic          accept;

    assign accept = (state == PS_IDLE) && vbaux_ok && (wake_hit || ks_hit);

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE: begin
                if (accept) state_nx = PS_DRIVE;
            end
            PS_DRIVE: begin
                if (!vbaux_ok)                    state_nx = PS_IDLE;
                else if (vcc_good)                state_nx = PS_HOLD;
                else if (tick && (tmr == T_LAST)) state_nx = PS_IDLE;
            end
            PS_HOLD: begin
                if (!vbaux_ok || !vcc_good) state_nx = PS_IDLE;
            end
            default: state_nx = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (state != PS_DRIVE) begin
            tmr <= '0;
        end else if (tick) begin
            tmr <= tmr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tdf <= 1'b0;
            ksf <= 1'b0;
        end else begin
            if (accept && wake_hit) tdf <= 1'b1;
            else if (flag_rd)       tdf <= 1'b0;
            if (accept && ks_hit)   ksf <= 1'b1;
            else if (flag_rd)       ksf <= 1'b0;
        end
    end

    always_comb begin
        pwr_oe = (state != PS_IDLE);
        pwr_n  = !pwr_oe;
    end
endmodule

// File: rtl/wk_power_ctl.sv
module wk_power_ctl
    import wk_power_pkg::*;
#(
    parameter int KS_MIN_TICKS      = 8,
    parameter int PWR_TIMEOUT_TICKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] cur_day,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_sec,
    input  logic [7:0] alm_day,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_sec,
    input  logic       wake_en,
    input  logic       xfer_en,
    input  logic       vcc_good,
    input  logic       vbaux_ok,
    input  logic       osc_run,
    input  logic       ks_n,
    input  logic       flag_rd,
    output logic       pwr_n,
    output logic       pwr_oe,
    output logic       tdf,
    output logic       ksf
);
    tod_t cur_t, alm_t;
    logic standby;
    logic wake_hit, ks_hit;

    assign cur_t   = '{day: cur_day, hour: cur_hour, min: cur_min, sec: cur_sec};
    assign alm_t   = '{day: alm_day, hour: alm_hour, min: alm_min, sec: alm_sec};
    assign standby = vbaux_ok && osc_run && !vcc_good;

    wk_alarm_cmp u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (standby && wake_en && xfer_en),
        .cur   (cur_t),
        .alm   (alm_t),
        .hit   (wake_hit)
    );

    wk_ks_qual #(.MIN_TICKS(KS_MIN_TICKS)) u_ks (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .active (standby),
        .ks_n   (ks_n),
        .fire   (ks_hit)
    );

    wk_pwr_fsm #(.TIMEOUT_TICKS(PWR_TIMEOUT_TICKS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .vbaux_ok (vbaux_ok),
        .vcc_good (vcc_good),
        .wake_hit (wake_hit),
        .ks_hit   (ks_hit),
        .flag_rd  (flag_rd),
        .pwr_n    (pwr_n),
        .pwr_oe   (pwr_oe),
        .tdf      (tdf),
        .ksf      (ksf)
    );
endmodule

// File: rtl/wk_power_chk.sv
module wk_power_chk (
    input logic clk,
    input logic rst_n,
    input logic vcc_good,
    input logic vbaux_ok,
    input logic flag_rd,
    input logic pwr_n,
    input logic pwr_oe,
    input logic tdf,
    input logic ksf
);
    // R2
    pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_oe |-> !pwr_n);

    // R2
    tdf_with_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tdf) |-> pwr_oe);

    // R4
    ksf_with_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ksf) |-> pwr_oe);

    // R3
    wake_needs_low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_oe && vcc_good |=> !pwr_oe);

    // R7
    supply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_oe && vcc_good && vbaux_ok |=> pwr_oe);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tdf || ksf) && !flag_rd |=> (tdf || ksf));

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd && pwr_oe |=> !tdf && !ksf);

    // R9
    no_flag_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_oe && !tdf && !ksf |=> !tdf && !ksf);

    // R10
    battery_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vbaux_ok |=> !pwr_oe);
endmodule

bind wk_power_ctl wk_power_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vcc_good (vcc_good),
    .vbaux_ok (vbaux_ok),
    .flag_rd  (flag_rd),
    .pwr_n    (pwr_n),
    .pwr_oe   (pwr_oe),
    .tdf      (tdf),
    .ksf      (ksf)
);

// File: tb/tb_wk_power_ctl.sv
module tb_wk_power_ctl;
    localparam int KS = 4;
    localparam int PO = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic tick;
    logic [7:0] cur_day, cur_hour, cur_min, cur_sec;
    logic [7:0] alm_day, alm_hour, alm_min, alm_sec;
    logic wake_en, xfer_en, vcc_good, vbaux_ok, osc_run, ks_n, flag_rd;
    logic pwr_n, pwr_oe, tdf, ksf;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    wk_power_ctl #(.KS_MIN_TICKS(KS), .PWR_TIMEOUT_TICKS(PO)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_day(cur_day), .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .alm_day(alm_day), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
        .wake_en(wake_en), .xfer_en(xfer_en), .vcc_good(vcc_good), .vbaux_ok(vbaux_ok),
        .osc_run(osc_run), .ks_n(ks_n), .flag_rd(flag_rd),
        .pwr_n(pwr_n), .pwr_oe(pwr_oe), .tdf(tdf), .ksf(ksf)
    );

    // Vector fields:
    //   [9:6] mismatch mask (day, hour, min, sec)
    //   [5] xfer_en   [4] wake_en   [3] vcc_good   [2] vbaux_ok   [1] osc_run
    //   [0] expected wake
    localparam logic [9:0] VEC [10] = '{
        10'b0000_110111,
        10'b1000_110110,
        10'b0100_110110,
        10'b0010_110110,
        10'b0001_110110,
        10'b0000_010110,
        10'b0000_100110,
        10'b0000_111110,
        10'b0000_110010,
        10'b0000_110100
    };

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            report();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset;
        rst_n    = 1'b0;
        tick     = 1'b1;
        alm_day  = 8'h15; alm_hour = 8'h07; alm_min = 8'h30; alm_sec = 8'h45;
        cur_day  = 8'h15; cur_hour = 8'h07; cur_min = 8'h30; cur_sec = 8'h46;
        wake_en  = 1'b0; xfer_en = 1'b0; vcc_good = 1'b0;
        vbaux_ok = 1'b1; osc_run = 1'b1; ks_n = 1'b1; flag_rd = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Arms the alarm wake and matches it; the output is driven from the next edge.
    task automatic fire_wake;
        wake_en = 1'b1; xfer_en = 1'b1;
        cur_sec = alm_sec;
        @(negedge clk);
    endtask

    task automatic ks_pulse(input int n);
        ks_n = 1'b0;
        repeat (n) @(negedge clk);
        ks_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1
        check("R1 pwr_oe", {31'd0, pwr_oe}, 32'd0);
        check("R1 pwr_n", {31'd0, pwr_n}, 32'd1);
        check("R1 flags", {30'd0, tdf, ksf}, 32'd0);

        // R2 / R3 vector table
        foreach (VEC[i]) begin
            do_reset();
            cur_day  = alm_day  + {7'd0, VEC[i][9]};
            cur_hour = alm_hour + {7'd0, VEC[i][8]};
            cur_min  = alm_min  + {7'd0, VEC[i][7]};
            cur_sec  = alm_sec  + {7'd0, VEC[i][6]};
            xfer_en  = VEC[i][5]; wake_en = VEC[i][4]; vcc_good = VEC[i][3];
            vbaux_ok = VEC[i][2]; osc_run = VEC[i][1];
            @(negedge clk);
            check($sformatf("R2 R3 vec%0d pwr_oe", i), {31'd0, pwr_oe}, {31'd0, VEC[i][0]});
            check($sformatf("R2 R3 vec%0d pwr_n", i), {31'd0, pwr_n}, {31'd0, ~VEC[i][0]});
            check($sformatf("R2 R3 vec%0d tdf", i), {31'd0, tdf}, {31'd0, VEC[i][0]});
        end

        // R6: timeout release after exactly PO ticks
        do_reset();
        fire_wake();
        check("R6 driven at start", {31'd0, pwr_oe}, 32'd1);
        repeat (PO - 1) @(negedge clk);
        check("R6 driven at PO-1", {31'd0, pwr_oe}, 32'd1);
        @(negedge clk);
        check("R6 released at PO", {30'd0, pwr_oe, pwr_n}, 32'd1);
        // R8: flag survives the release, then a read clears it
        check("R8 tdf sticky", {31'd0, tdf}, 32'd1);
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
        check("R8 tdf cleared", {31'd0, tdf}, 32'd0);

        // R6: stopped ticks freeze the timer
        do_reset();
        fire_wake();
        tick = 1'b0;
        repeat (PO + 8) @(negedge clk);
        check("R6 no tick no timeout", {31'd0, pwr_oe}, 32'd1);
        tick = 1'b1;
        repeat (PO) @(negedge clk);
        check("R6 resumed ticks release", {31'd0, pwr_oe}, 32'd0);

        // R4: pulse of exactly KS ticks qualifies
        do_reset();
        ks_pulse(KS);
        repeat (3) @(negedge clk);
        check("R4 ks minimum pulse pwr_oe", {31'd0, pwr_oe}, 32'd1);
        check("R4 ksf set tdf clear", {30'd0, tdf, ksf}, 32'd1);

        // R4: one tick short is ignored
        do_reset();
        ks_pulse(KS - 1);
        repeat (6) @(negedge clk);
        check("R4 short pulse ignored", {29'd0, pwr_oe, tdf, ksf}, 32'd0);

        // R5: kickstart blocked while the main supply is good
        do_reset();
        vcc_good = 1'b1;
        ks_pulse(KS + 2);
        repeat (4) @(negedge clk);
        check("R5 ks blocked by vcc_good", {30'd0, pwr_oe, ksf}, 32'd0);

        // R5: a held low level fires only once
        do_reset();
        ks_n = 1'b0;
        repeat (KS + 2) @(negedge clk);
        check("R5 held low fires", {31'd0, pwr_oe}, 32'd1);
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
        repeat (PO + KS + 6) @(negedge clk);
        check("R5 held low no retrigger", {30'd0, pwr_oe, ksf}, 32'd0);
        ks_n = 1'b1;

        // R9: kickstart while driven is ignored
        do_reset();
        fire_wake();
        ks_pulse(KS + 2);
        repeat (3) @(negedge clk);
        check("R9 ks ignored while driven", {31'd0, ksf}, 32'd0);

        // R7: supply arrives before the timeout
        do_reset();
        fire_wake();
        repeat (3) @(negedge clk);
        vcc_good = 1'b1;
        repeat (PO + 5) @(negedge clk);
        check("R7 held past timeout", {30'd0, pwr_oe, pwr_n}, 32'd2);
        vcc_good = 1'b0;
        @(negedge clk);
        check("R7 released after supply drop", {31'd0, pwr_oe}, 32'd0);

        // R10: battery loss releases the output
        do_reset();
        fire_wake();
        repeat (2) @(negedge clk);
        vbaux_ok = 1'b0;
        @(negedge clk);
        check("R10 battery loss release", {30'd0, pwr_oe, pwr_n}, 32'd1);

        report();
    end
endmodule